// File: doc/BRIEF.md
# Register-Direct Integer ALU Execute Unit

This block executes one 32-bit two-operand integer instruction per strobe. Both operands come from an internal file of eight general registers. The caller presents an opcode byte, a flag that marks a leading 0x0F escape byte, and an operand-selector byte. On the next clock edge the block writes the result back to the register file and updates the sign (SF), zero (ZF) and overflow (OF) flags.

The supported operations are:
- add, subtract, AND, OR and XOR;
- compare, which writes no register;
- copy and swap;
- bitwise invert, negate and a widening unsigned multiply;
- a signed multiply reached through the escape byte.

Any encoding outside this set, and any selector that names a memory operand, is refused. A refused encoding raises an illegal indication and changes no state.

A side port seeds one register per cycle, and a combinational read port shows any register. These two ports let the surrounding pipeline, or a bench, set up operands and observe results.

Top module: `rdir_alu_exec`

## Requirements
- R1: After reset all eight registers read 0, SF, ZF and OF are 0, and `out_done` and `out_illegal` are low.
- R2: A cycle with `in_valid` high gives `out_done` high on the next cycle, with the results already visible. A cycle with `in_valid` low gives `out_done` low on the next cycle.
- R3: The selector byte is split into three fields: bits 7:6 are the mode, bits 5:3 the reg field, and bits 2:0 the r/m field. The reg field is also the sub-operation for opcode 0xF7. Register indices 0 to 7 are the accumulator (0), counter (1), data (2), base (3), stack pointer (4), frame pointer (5), source index (6) and destination index (7).
- R4: Opcode 0x01 writes r/m + reg into r/m, and opcode 0x29 writes r/m - reg into r/m. For both, SF is bit 31 of the result, ZF is set when the result is zero, and OF is set on signed overflow.
- R5: Opcodes 0x21, 0x09 and 0x31 write r/m AND, OR or XOR reg into r/m. They take SF and ZF from the result and clear OF.
- R6: Opcode 0x39 sets SF, ZF and OF exactly as a subtract would, and writes no register.
- R7: Opcode 0x89 copies reg into r/m. Opcode 0x87 exchanges reg and r/m in one step. Neither changes any flag.
- R8: Opcode 0xF7 with sub-operation 4 forms the unsigned 64-bit product of register 0 and r/m. The low word goes to register 0 and the high word to register 2. OF is set exactly when the high word is nonzero, and SF and ZF are left unchanged.
- R9: Opcode 0xF7 with sub-operation 3 negates r/m and takes SF and ZF from the result, with OF=0. For the operand 0x80000000, r/m is left as it is, and the flags become SF=1, ZF=0 and OF=1.
- R10: Opcode 0xF7 with sub-operation 2 inverts every bit of r/m. It takes SF and ZF from the result and clears OF.
- R11: With the escape flag set, opcode 0xAF writes the low 32 bits of the signed product reg × r/m into reg. It takes SF and ZF from the written value, and sets OF when the full signed product does not fit in 32 bits.
- R12: The following are illegal:
  - a mode other than 3;
  - an unlisted opcode;
  - opcode 0xF7 with a sub-operation other than 2, 3 or 4;
  - the escape flag set with an opcode other than 0xAF;
  - opcode 0xAF without the escape flag.

  An illegal encoding gives `out_illegal` together with `out_done`, and leaves every register and every flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Execute strobe for the presented instruction |
| in_esc | input | 1 | Instruction was preceded by the 0x0F escape byte |
| in_opc | input | 8 | Opcode byte |
| in_modrm | input | 8 | Operand-selector byte (mode, reg, r/m) |
| ld_en | input | 1 | Seed-write strobe into the register file |
| ld_idx | input | 3 | Register index for the seed write |
| ld_data | input | 32 | Seed-write value |
| rd_idx | input | 3 | Register index for the observation read |
| rd_data | output | 32 | Combinational value of register `rd_idx` |
| out_done | output | 1 | Instruction completed (one cycle after the strobe) |
| out_illegal | output | 1 | Completed instruction was an unsupported encoding |
| out_sf | output | 1 | Sign flag |
| out_zf | output | 1 | Zero flag |
| out_of | output | 1 | Overflow flag |

## Verification
The register file and the flag registers are the only state, so a wrong value in either is visible at `rd_data` or on the flag pins as soon as the completing edge has passed. The bench reads them in the cycle of `out_done`. The hazards are these:
- a wrong write index sends a correct result to the wrong register;
- a missing write-enable gate lets compare or the negate corner case overwrite its operand;
- a flag enable that is too wide makes copy or multiply clobber SF or ZF.

Each of these is caught by reading the neighbouring registers and flags that should have held still. Illegal encodings are checked the same way, against state that was seeded deliberately beforehand.

// File: rtl/alux_pkg.sv
package alux_pkg;

   localparam int SEL_W   = 3;
   localparam int IDX_ACC = 0;
   localparam int IDX_HI  = 2;

   localparam logic [7:0] OPC_ADD  = 8'h01;
   localparam logic [7:0] OPC_SUB  = 8'h29;
   localparam logic [7:0] OPC_AND  = 8'h21;
   localparam logic [7:0] OPC_OR   = 8'h09;
   localparam logic [7:0] OPC_XOR  = 8'h31;
   localparam logic [7:0] OPC_CMP  = 8'h39;
   localparam logic [7:0] OPC_MOV  = 8'h89;
   localparam logic [7:0] OPC_XCHG = 8'h87;
   localparam logic [7:0] OPC_GRP  = 8'hF7;
   localparam logic [7:0] OPC_MULS = 8'hAF;

   localparam logic [2:0] SUB_NOT = 3'd2;
   localparam logic [2:0] SUB_NEG = 3'd3;
   localparam logic [2:0] SUB_MUL = 3'd4;

   typedef enum logic [3:0] {
      OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_CMP, OP_MOV,
      OP_XCHG, OP_NOT, OP_NEG, OP_MULU, OP_MULS, OP_BAD
   } alu_op_e;

   typedef struct packed {
      alu_op_e          op;
      logic [SEL_W-1:0] rsel;
      logic [SEL_W-1:0] msel;
      logic             bad;
   } dec_t;

endpackage

// File: rtl/alux_decode.sv
module alux_decode
   import alux_pkg::*;
(
   input  logic       esc,
   input  logic [7:0] opc,
   input  logic [7:0] modrm,
   output dec_t       dec
);

   logic [1:0]       mode;
   logic [SEL_W-1:0] fld_reg;
   alu_op_e          op_raw;

   assign mode    = modrm[7:6];
   assign fld_reg = modrm[5:3];

   always_comb begin
      op_raw = OP_BAD;
      if (esc) begin
         if (opc == OPC_MULS) op_raw = OP_MULS;
      end else begin
         unique case (opc)
            OPC_ADD:  op_raw = OP_ADD;
            OPC_SUB:  op_raw = OP_SUB;
            OPC_AND:  op_raw = OP_AND;
            OPC_OR:   op_raw = OP_OR;
            OPC_XOR:  op_raw = OP_XOR;
            OPC_CMP:  op_raw = OP_CMP;
            OPC_MOV:  op_raw = OP_MOV;
            OPC_XCHG: op_raw = OP_XCHG;
            OPC_GRP: begin
               if      (fld_reg == SUB_NOT) op_raw = OP_NOT;
               else if (fld_reg == SUB_NEG) op_raw = OP_NEG;
               else if (fld_reg == SUB_MUL) op_raw = OP_MULU;
               else                         op_raw = OP_BAD;
            end
            default:  op_raw = OP_BAD;
         endcase
      end
   end

   always_comb begin
      dec.rsel = fld_reg;
      dec.msel = modrm[2:0];
      dec.bad  = (mode != 2'b11) || (op_raw == OP_BAD);
      dec.op   = dec.bad ? OP_BAD : op_raw;
   end

endmodule

// File: rtl/alux_datapath.sv
module alux_datapath
   import alux_pkg::*;
#(
   parameter int W = 32
) (
   input  alu_op_e          op,
   input  logic [SEL_W-1:0] rsel,
   input  logic [SEL_W-1:0] msel,
   input  logic [W-1:0]     a,
   input  logic [W-1:0]     b,
   input  logic [W-1:0]     acc,
   output logic             wa_en,
   output logic [SEL_W-1:0] wa_idx,
   output logic [W-1:0]     wa_d,
   output logic             wb_en,
   output logic [SEL_W-1:0] wb_idx,
   output logic [W-1:0]     wb_d,
   output logic             sz_we,
   output logic             of_we,
   output logic             sf_n,
   output logic             zf_n,
   output logic             of_n
);

   localparam int          PW      = 2 * W;
   localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

   logic [W-1:0]         sum, dif, r;
   logic [PW-1:0]        pu;
   logic signed [PW-1:0] ps;

   assign sum = a + b;
   assign dif = a - b;
   assign pu  = {{W{1'b0}}, acc} * {{W{1'b0}}, a};
   assign ps  = $signed({{W{b[W-1]}}, b}) * $signed({{W{a[W-1]}}, a});

   always_comb begin
      r      = '0;
      wa_en  = 1'b0;
      wb_en  = 1'b0;
      wa_idx = msel;
      wb_idx = rsel;
      wb_d   = a;
      sz_we  = 1'b0;
      of_we  = 1'b0;
      of_n   = 1'b0;
      unique case (op)
         OP_ADD: begin
            r = sum; wa_en = 1'b1; sz_we = 1'b1; of_we = 1'b1;
            of_n = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
         end
         OP_SUB, OP_CMP: begin
            r = dif; wa_en = (op == OP_SUB); sz_we = 1'b1; of_we = 1'b1;
            of_n = (a[W-1] != b[W-1]) && (dif[W-1] != a[W-1]);
         end
         OP_AND: begin r = a & b; wa_en = 1'b1; sz_we = 1'b1; of_we = 1'b1; end
         OP_OR:  begin r = a | b; wa_en = 1'b1; sz_we = 1'b1; of_we = 1'b1; end
         OP_XOR: begin r = a ^ b; wa_en = 1'b1; sz_we = 1'b1; of_we = 1'b1; end
         OP_NOT: begin r = ~a;    wa_en = 1'b1; sz_we = 1'b1; of_we = 1'b1; end
         OP_NEG: begin
            sz_we = 1'b1; of_we = 1'b1;
            if (a == MIN_NEG) begin
               r = a; of_n = 1'b1;
            end else begin
               r = -a; wa_en = 1'b1;
            end
         end
         OP_MOV:  begin r = b; wa_en = 1'b1; end
         OP_XCHG: begin r = b; wa_en = 1'b1; wb_en = 1'b1; end
         OP_MULU: begin
            r = pu[W-1:0]; wa_en = 1'b1; wa_idx = SEL_W'(IDX_ACC);
            wb_en = 1'b1; wb_idx = SEL_W'(IDX_HI); wb_d = pu[PW-1:W];
            of_we = 1'b1; of_n = |pu[PW-1:W];
         end
         OP_MULS: begin
            r = ps[W-1:0]; wa_en = 1'b1; wa_idx = rsel;
            sz_we = 1'b1; of_we = 1'b1;
            of_n = (ps[PW-1:W] != {W{ps[W-1]}});
         end
         default: r = '0;
      endcase
      wa_d = r;
      sf_n = r[W-1];
      zf_n = ~|r;
   end

endmodule

// File: rtl/alux_regfile.sv
module alux_regfile #(
   parameter int W     = 32,
   parameter int NREG  = 8,
   parameter int IDX_W = $clog2(NREG)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wa_en,
   input  logic [IDX_W-1:0]          wa_idx,
   input  logic [W-1:0]              wa_d,
   input  logic                      wb_en,
   input  logic [IDX_W-1:0]          wb_idx,
   input  logic [W-1:0]              wb_d,
   input  logic                      ld_en,
   input  logic [IDX_W-1:0]          ld_idx,
   input  logic [W-1:0]              ld_d,
   output logic [NREG-1:0][W-1:0]    q
);

   generate
      if (NREG != (1 << IDX_W)) begin : g_chk_depth
         $error("alux_regfile: NREG must be a power of two");
      end
      for (genvar g = 0; g < NREG; g++) begin : g_ent
         logic [W-1:0] val;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                   val <= '0;
            else if (wb_en && wb_idx == IDX_W'(g))        val <= wb_d;
            else if (wa_en && wa_idx == IDX_W'(g))        val <= wa_d;
            else if (ld_en && ld_idx == IDX_W'(g))        val <= ld_d;
         end
         assign q[g] = val;
      end
   endgenerate

   // R12: with no write request the stored registers hold their value
   p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !(wa_en || wb_en || ld_en) |=> $stable(q));

endmodule

// File: rtl/rdir_alu_exec.sv
module rdir_alu_exec
   import alux_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_esc,
   input  logic [7:0]        in_opc,
   input  logic [7:0]        in_modrm,
   input  logic              ld_en,
   input  logic [2:0]        ld_idx,
   input  logic [DATA_W-1:0] ld_data,
   input  logic [2:0]        rd_idx,
   output logic [DATA_W-1:0] rd_data,
   output logic              out_done,
   output logic              out_illegal,
   output logic              out_sf,
   output logic              out_zf,
   output logic              out_of
);

   localparam int NREG = 1 << SEL_W;

   generate
      if (DATA_W < 2) begin : g_chk_width
         $error("rdir_alu_exec: DATA_W must be at least 2");
      end
   endgenerate

   dec_t                          dec;
   logic [NREG-1:0][DATA_W-1:0]   rf_q;
   logic                          go;
   logic                          dp_wa_en, dp_wb_en, dp_sz_we, dp_of_we;
   logic [SEL_W-1:0]              dp_wa_idx, dp_wb_idx;
   logic [DATA_W-1:0]             dp_wa_d, dp_wb_d;
   logic                          dp_sf, dp_zf, dp_of;

   alux_decode u_dec (
      .esc   (in_esc),
      .opc   (in_opc),
      .modrm (in_modrm),
      .dec   (dec)
   );

   alux_datapath #(.W(DATA_W)) u_dp (
      .op     (dec.op),
      .rsel   (dec.rsel),
      .msel   (dec.msel),
      .a      (rf_q[dec.msel]),
      .b      (rf_q[dec.rsel]),
      .acc    (rf_q[IDX_ACC]),
      .wa_en  (dp_wa_en),
      .wa_idx (dp_wa_idx),
      .wa_d   (dp_wa_d),
      .wb_en  (dp_wb_en),
      .wb_idx (dp_wb_idx),
      .wb_d   (dp_wb_d),
      .sz_we  (dp_sz_we),
      .of_we  (dp_of_we),
      .sf_n   (dp_sf),
      .zf_n   (dp_zf),
      .of_n   (dp_of)
   );

   assign go = in_valid && !dec.bad;

   alux_regfile #(.W(DATA_W), .NREG(NREG)) u_rf (
      .clk    (clk),
      .rst_n  (rst_n),
      .wa_en  (go && dp_wa_en),
      .wa_idx (dp_wa_idx),
      .wa_d   (dp_wa_d),
      .wb_en  (go && dp_wb_en),
      .wb_idx (dp_wb_idx),
      .wb_d   (dp_wb_d),
      .ld_en  (ld_en),
      .ld_idx (ld_idx),
      .ld_d   (ld_data),
      .q      (rf_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_sf      <= 1'b0;
         out_zf      <= 1'b0;
         out_of      <= 1'b0;
         out_done    <= 1'b0;
         out_illegal <= 1'b0;
      end else begin
         out_done    <= in_valid;
         out_illegal <= in_valid && dec.bad;
         if (go && dp_sz_we) begin
            out_sf <= dp_sf;
            out_zf <= dp_zf;
         end
         if (go && dp_of_we) out_of <= dp_of;
      end
   end

   assign rd_data = rf_q[rd_idx];

   // R2: completion one cycle after each strobe
   p_done_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_done);
   // R2: no completion without a strobe
   p_done_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_done);
   // R12: an illegal completion changes no flag
   p_illegal_flags_r12: assert property (@(posedge clk) disable iff (!rst_n)
      out_illegal |-> (out_done && $stable({out_sf, out_zf, out_of})));
   // R4: a zero result is never reported as negative
   p_zero_not_neg_r4: assert property (@(posedge clk) disable iff (!rst_n)
      out_zf |-> !out_sf);
   // R9: negating the most negative value reports overflow
   p_neg_min_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (go && dec.op == OP_NEG && rf_q[dec.msel] == {1'b1, {(DATA_W-1){1'b0}}})
      |=> (out_of && out_sf && !out_zf));

endmodule

// File: tb/sim_rdir_alu_exec.sv
module sim_rdir_alu_exec;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0, in_esc = 1'b0;
   logic [7:0]  in_opc = '0, in_modrm = '0;
   logic        ld_en = 1'b0;
   logic [2:0]  ld_idx = '0, rd_idx = '0;
   logic [31:0] ld_data = '0;
   logic [31:0] rd_data;
   logic        out_done, out_illegal, out_sf, out_zf, out_of;
   int          total = 0, bad = 0;

   always #5 clk = ~clk;

   rdir_alu_exec #(.DATA_W(32)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_esc(in_esc),
      .in_opc(in_opc), .in_modrm(in_modrm), .ld_en(ld_en), .ld_idx(ld_idx),
      .ld_data(ld_data), .rd_idx(rd_idx), .rd_data(rd_data),
      .out_done(out_done), .out_illegal(out_illegal),
      .out_sf(out_sf), .out_zf(out_zf), .out_of(out_of)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic setr(input logic [2:0] i, input logic [31:0] v);
      @(negedge clk);
      ld_en = 1'b1; ld_idx = i; ld_data = v;
      @(negedge clk);
      ld_en = 1'b0;
   endtask

   task automatic expr(input string tag, input logic [2:0] i, input logic [31:0] e);
      rd_idx = i;
      #1;
      chk(tag, rd_data, e);
   endtask

   task automatic expf(input string tag, input logic [2:0] e);
      chk({tag, " flags{sf,zf,of}"}, 32'({out_sf, out_zf, out_of}), 32'(e));
   endtask

   task automatic exec(input string tag, input logic esc, input logic [7:0] opc,
                       input logic [7:0] modrm, input logic exp_ill);
      @(negedge clk);
      in_valid = 1'b1; in_esc = esc; in_opc = opc; in_modrm = modrm;
      @(posedge clk);
      #1;
      chk({tag, " done R2"}, 32'(out_done), 32'd1);
      chk({tag, " illegal R12"}, 32'(out_illegal), 32'(exp_ill));
      @(negedge clk);
      in_valid = 1'b0; in_esc = 1'b0;
   endtask

   task automatic t_reset;
      for (int i = 0; i < 8; i++) expr("R1 reg after reset", 3'(i), 32'h0);
      expf("R1", 3'b000);
      chk("R1 done", 32'(out_done), 32'd0);
      chk("R1 illegal", 32'(out_illegal), 32'd0);
   endtask

   task automatic t_add;
      setr(0, 32'h10); setr(3, 32'h1);
      exec("R4 add", 1'b0, 8'h01, 8'hD8, 1'b0);
      expr("R4 add result", 0, 32'h11); expr("R3 base untouched", 3, 32'h1);
      expf("R4 add", 3'b000);
      @(posedge clk); #1;
      chk("R2 done drops", 32'(out_done), 32'd0);
      setr(0, 32'h7fffffff);
      exec("R4 add ovf", 1'b0, 8'h01, 8'hD8, 1'b0);
      expr("R4 add ovf result", 0, 32'h80000000);
      expf("R4 add ovf", 3'b101);
   endtask

   task automatic t_sub;
      setr(0, 32'd10); setr(3, 32'd1);
      exec("R4 sub", 1'b0, 8'h29, 8'hD8, 1'b0);
      expr("R4 sub result", 0, 32'd9); expf("R4 sub", 3'b000);
      setr(0, 32'd5); setr(3, 32'd5);
      exec("R4 sub zero", 1'b0, 8'h29, 8'hD8, 1'b0);
      expr("R4 sub zero result", 0, 32'd0); expf("R4 sub zero", 3'b010);
   endtask

   task automatic t_move;
      setr(3, 32'haf);
      exec("R7 copy", 1'b0, 8'h89, 8'hD8, 1'b0);
      expr("R7 copy result", 0, 32'haf); expf("R7 copy keeps", 3'b010);
      setr(0, 32'h2e);
      exec("R7 swap", 1'b0, 8'h87, 8'hD8, 1'b0);
      expr("R7 swap rm", 0, 32'haf); expr("R7 swap reg", 3, 32'h2e);
      expf("R7 swap keeps", 3'b010);
      setr(4, 32'h11); setr(7, 32'h22);
      exec("R3 swap sp/di", 1'b0, 8'h87, 8'hE7, 1'b0);
      expr("R3 stack ptr", 4, 32'h22); expr("R3 dest idx", 7, 32'h11);
   endtask

   task automatic t_logic;
      setr(0, 32'h7fffffff); setr(3, 32'h1);
      exec("R5 pre ovf", 1'b0, 8'h01, 8'hD8, 1'b0);
      setr(3, 32'hff);
      exec("R5 and clears of", 1'b0, 8'h21, 8'hD8, 1'b0);
      expr("R5 and zero", 0, 32'h0); expf("R5 and zero", 3'b010);
      setr(0, 32'h0a0b0c0d);
      exec("R5 and", 1'b0, 8'h21, 8'hD8, 1'b0);
      expr("R5 and result", 0, 32'h0000000d); expf("R5 and", 3'b000);
      setr(0, 32'h0a0b0c0d); setr(3, 32'ha0b0c0d0);
      exec("R5 or", 1'b0, 8'h09, 8'hD8, 1'b0);
      expr("R5 or result", 0, 32'haabbccdd); expf("R5 or", 3'b100);
      setr(0, 32'h0a0b0c0d); setr(3, 32'haabbc0d0);
      exec("R5 xor", 1'b0, 8'h31, 8'hD8, 1'b0);
      expr("R5 xor result", 0, 32'ha0b0ccdd); expf("R5 xor", 3'b100);
      exec("R5 xor self", 1'b0, 8'h31, 8'hC0, 1'b0);
      expr("R5 xor self result", 0, 32'h0); expf("R5 xor self", 3'b010);
   endtask

   task automatic t_cmp;
      setr(0, 32'h0a0b0c07); setr(3, 32'h0a0b0c0d);
      exec("R6 cmp less", 1'b0, 8'h39, 8'hD8, 1'b0);
      expr("R6 no write", 0, 32'h0a0b0c07); expf("R6 cmp less", 3'b100);
      setr(0, 32'h0a0b0c0d);
      exec("R6 cmp equal", 1'b0, 8'h39, 8'hD8, 1'b0);
      expf("R6 cmp equal", 3'b010);
      setr(0, 32'h80000000); setr(3, 32'h1);
      exec("R6 cmp ovf", 1'b0, 8'h39, 8'hD8, 1'b0);
      expr("R6 no write ovf", 0, 32'h80000000); expf("R6 cmp ovf", 3'b001);
   endtask

   task automatic t_neg;
      setr(3, 32'h1);
      exec("R9 neg", 1'b0, 8'hF7, 8'hDB, 1'b0);
      expr("R9 neg result", 3, 32'hffffffff); expf("R9 neg", 3'b100);
      setr(3, 32'h0);
      exec("R9 neg zero", 1'b0, 8'hF7, 8'hDB, 1'b0);
      expr("R9 neg zero result", 3, 32'h0); expf("R9 neg zero", 3'b010);
      setr(3, 32'h80000000);
      exec("R9 neg min", 1'b0, 8'hF7, 8'hDB, 1'b0);
      expr("R9 neg min kept", 3, 32'h80000000); expf("R9 neg min", 3'b101);
   endtask

   task automatic t_mul;
      setr(0, 32'd4); setr(1, 32'd3); setr(2, 32'h55);
      exec("R8 mul", 1'b0, 8'hF7, 8'hE1, 1'b0);
      expr("R8 mul low", 0, 32'd12); expr("R8 mul high", 2, 32'h0);
      expf("R8 mul keeps sf zf", 3'b100);
      setr(0, 32'hffffffff); setr(1, 32'hffffffff);
      exec("R8 mul wide", 1'b0, 8'hF7, 8'hE1, 1'b0);
      expr("R8 wide low", 0, 32'h1); expr("R8 wide high", 2, 32'hfffffffe);
      expf("R8 mul wide", 3'b101);
   endtask

   task automatic t_not;
      setr(3, 32'h0f0f00ff);
      exec("R10 not", 1'b0, 8'hF7, 8'hD3, 1'b0);
      expr("R10 not result", 3, 32'hf0f0ff00); expf("R10 not", 3'b100);
   endtask

   task automatic t_imul;
      setr(0, 32'd4); setr(3, 32'd2);
      exec("R11 imul", 1'b1, 8'hAF, 8'hD8, 1'b0);
      expr("R11 imul result", 3, 32'd8); expr("R11 rm kept", 0, 32'd4);
      expf("R11 imul", 3'b000);
      setr(0, 32'hfffffffd); setr(3, 32'd5);
      exec("R11 imul neg", 1'b1, 8'hAF, 8'hD8, 1'b0);
      expr("R11 imul neg result", 3, 32'hfffffff1); expf("R11 imul neg", 3'b100);
      setr(0, 32'h10000); setr(3, 32'h10000);
      exec("R11 imul ovf", 1'b1, 8'hAF, 8'hD8, 1'b0);
      expr("R11 imul ovf result", 3, 32'h0); expf("R11 imul ovf", 3'b011);
   endtask

   task automatic t_illegal;
      setr(0, 32'h33); setr(3, 32'h1);
      exec("R12 mode0", 1'b0, 8'h01, 8'h18, 1'b1);
      expr("R12 mode0 no write", 0, 32'h33); expf("R12 mode0", 3'b011);
      exec("R12 grp sub0", 1'b0, 8'hF7, 8'hC3, 1'b1);
      expr("R12 grp no write", 3, 32'h1);
      exec("R12 esc bad", 1'b1, 8'h01, 8'hD8, 1'b1);
      expr("R12 esc no write", 0, 32'h33);
      exec("R12 af no esc", 1'b0, 8'hAF, 8'hD8, 1'b1);
      expr("R12 af no write", 3, 32'h1);
      exec("R12 unknown opc", 1'b0, 8'h00, 8'hD8, 1'b1);
      expr("R12 unknown no write", 0, 32'h33); expf("R12 end", 3'b011);
   endtask

   initial begin
      #1_000_000;
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      t_reset();
      rst_n = 1'b1;
      t_add();
      t_sub();
      t_move();
      t_logic();
      t_cmp();
      t_neg();
      t_mul();
      t_not();
      t_imul();
      t_illegal();
      repeat (2) @(negedge clk);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule